// File: doc/BRIEF.md
# SPI Word Transfer Engine with Chip-Select Hold

This block is the bit-level shift engine placed under a memory-mapped serial-flash controller. A requester hands over one word of up to 32 bits and a 2-bit length code in a single cycle. The engine then drives a mode-0 SPI clock at half the system clock and sends the upper 8, 16, 24 or 32 bits of the word on MOSI, most significant bit first. At the same time it collects MISO into a receive word. When the last bit has been clocked, it pulses a one-cycle valid strobe with the received data.

Requests can be chained. A request that arrives during the final bit period of the current word is staged and begins at the completion edge, so busy stays high and SCK keeps running without a gap. Back-to-back 32-bit reads therefore stream continuously. A separate hold input keeps chip select low after a word finishes with nothing queued. A later request then continues the same transaction without a new select phase. When hold is low and nothing is pending, chip select is released and the engine goes idle. An external select input from another bus master blocks the start of a new transaction while it is low.

Top module: `spi_word_engine`

## Requirements
- R1: The length code picks the word size: 2'b00 gives 8 bits, 2'b01 gives 16, 2'b10 gives 24 and 2'b11 gives 32. A word accepted on clock edge E0 completes on edge E0+2N, where N is the bit count.
- R2: MOSI carries the request word from bit 31 downward, one bit per SCK period. Only the top N bits are sent.
- R3: Received bits enter at bit 0 and shift upward. At completion, rx_word[N-1:0] holds the N bits received, with the first one at bit N-1, and every bit above N-1 is zero.
- R4: rx_valid is high for exactly one cycle, in the cycle after the completion edge. busy is high from the cycle after acceptance until completion.
- R5: If hold is high at completion and no request is queued, cs_n stays low and busy drops. The next request continues the transaction without a new chip-select fall.
- R6: SCK idles low. While busy, SCK is low in the first cycle of each bit and high in the second, so it toggles every clock. MISO is sampled on the rising SCK edge.
- R7: A request raised during the final bit period starts at the completion edge. busy stays high and cs_n stays low, so consecutive words run without a gap.
- R8: If hold is low at completion with nothing queued, cs_n goes high and the engine returns to idle. Dropping hold while held with no request also releases cs_n on the next edge.
- R9: A request raised while busy, before the final bit period, is ignored. The current word completes unchanged and no further word follows.
- R10: While ext_cs_n is low, a request in idle is dropped: cs_n stays high and busy stays low.
- R11: After reset, cs_n is 1, and sck, busy, rx_valid and rx_word are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_wr | input | 1 | Transfer request strobe |
| req_hold | input | 1 | Keep chip select low after the word completes |
| req_word | input | 32 | Transmit word, sent from bit 31 down |
| req_len | input | 2 | Length code: (code+1)*8 bits |
| ext_cs_n | input | 1 | Low while another master owns the bus |
| miso | input | 1 | Serial data from the slave |
| rx_word | output | 32 | Received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe when rx_word is updated |
| busy | output | 1 | High while a word is being shifted |
| sck | output | 1 | Serial clock, mode 0, half the system rate |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the slave |

## Verification
A wrong bit counter shows up as rx_valid arriving earlier or later than 2N edges after acceptance. It is detected on the very first word of the affected length. A bad shift or load path corrupts the MOSI bits captured by the modelled slave, or the right-aligned rx_word, when that word completes. A wrong staging or hold decision shows up at the completion edge as busy dropping between streamed words, or as cs_n rising, or failing to rise, one cycle after the last bit. An extra chip-select fall counted by the slave exposes a held transaction that was wrongly restarted.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

   typedef enum logic [1:0] {
      ENG_IDLE  = 2'd0,
      ENG_SHIFT = 2'd1,
      ENG_HELD  = 2'd2
   } eng_state_e;

endpackage

// File: rtl/spi_eng_clkgen.sv
module spi_eng_clkgen (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic load,
   output logic sck,
   output logic rise_now,
   output logic fall_now
);

   logic sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sck_q <= 1'b0;
      else if (load || !run)
         sck_q <= 1'b0;
      else
         sck_q <= ~sck_q;
   end

   // the edge coming next raises or lowers SCK
   assign rise_now = run && !sck_q;
   assign fall_now = run &&  sck_q;
   assign sck      = sck_q;

endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter #(
   parameter int WORD_W        = 32,
   parameter bit RX_CLR_ON_LOAD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   input  logic              rise_now,
   input  logic              fall_now,
   input  logic              miso,
   output logic              mosi,
   output logic [WORD_W-1:0] rx_sr
);

   logic [WORD_W-1:0] tx_q;
   logic [WORD_W-1:0] rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tx_q <= '0;
      else if (load)
         tx_q <= load_word;
      else if (fall_now)
         tx_q <= {tx_q[WORD_W-2:0], 1'b0};
   end

   generate
      if (RX_CLR_ON_LOAD) begin : g_rx_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               rx_q <= '0;
            else if (load)
               rx_q <= '0;
            else if (rise_now)
               rx_q <= {rx_q[WORD_W-2:0], miso};
         end
      end else begin : g_rx_keep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               rx_q <= '0;
            else if (rise_now)
               rx_q <= {rx_q[WORD_W-2:0], miso};
         end
      end
   endgenerate

   assign mosi  = tx_q[WORD_W-1];
   assign rx_sr = rx_q;

endmodule

// File: rtl/spi_eng_seq.sv
module spi_eng_seq
   import spi_eng_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int LEN_W  = 2,
   parameter int UNIT_W = 8,
   localparam int CNT_W = $clog2(WORD_W) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_wr,
   input  logic              req_hold,
   input  logic [WORD_W-1:0] req_word,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              ext_cs_n,
   input  logic              fall_now,
   input  logic [WORD_W-1:0] rx_sr,
   output logic              load,
   output logic [WORD_W-1:0] load_word,
   output logic              run,
   output logic              cs_n,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_valid
);

   eng_state_e        st_q;
   logic [CNT_W-1:0]  bits_q;
   logic              pend_v_q;
   logic [WORD_W-1:0] pend_word_q;
   logic [LEN_W-1:0]  pend_len_q;
   logic              cs_n_q;
   logic [WORD_W-1:0] rx_word_q;
   logic              rx_valid_q;

   logic              last_bit;
   logic              done;
   logic              start_new;
   logic              start_cont;
   logic              chain;
   logic              use_pend;
   logic [LEN_W-1:0]  load_len;
   logic [CNT_W-1:0]  load_bits;
   logic              stage;

   always_comb begin
      last_bit   = (st_q == ENG_SHIFT) && (bits_q == CNT_W'(1));
      done       = last_bit && fall_now;
      start_new  = (st_q == ENG_IDLE) && req_wr && ext_cs_n;
      start_cont = (st_q == ENG_HELD) && req_wr;
      chain      = done && (pend_v_q || req_wr);
      use_pend   = done && pend_v_q;
      load       = start_new || start_cont || chain;
      load_word  = use_pend ? pend_word_q : req_word;
      load_len   = use_pend ? pend_len_q  : req_len;
      load_bits  = CNT_W'((int'(load_len) + 1) * UNIT_W);
      stage      = last_bit && !fall_now && req_wr && !pend_v_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bits_q <= '0;
      end else if (load) begin
         bits_q <= load_bits;
      end else if (fall_now && (st_q == ENG_SHIFT)) begin
         bits_q <= bits_q - CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v_q    <= 1'b0;
         pend_word_q <= '0;
         pend_len_q  <= '0;
      end else if (load) begin
         pend_v_q <= 1'b0;
      end else if (stage) begin
         pend_v_q    <= 1'b1;
         pend_word_q <= req_word;
         pend_len_q  <= req_len;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_word_q  <= '0;
         rx_valid_q <= 1'b0;
      end else begin
         rx_valid_q <= done;
         if (done)
            rx_word_q <= rx_sr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ENG_IDLE;
         cs_n_q <= 1'b1;
      end else begin
         unique case (st_q)
            ENG_IDLE: begin
               if (start_new) begin
                  st_q   <= ENG_SHIFT;
                  cs_n_q <= 1'b0;
               end
            end
            ENG_SHIFT: begin
               if (done && !chain) begin
                  if (req_hold) begin
                     st_q <= ENG_HELD;
                  end else begin
                     st_q   <= ENG_IDLE;
                     cs_n_q <= 1'b1;
                  end
               end
            end
            ENG_HELD: begin
               if (req_wr) begin
                  st_q <= ENG_SHIFT;
               end else if (!req_hold) begin
                  st_q   <= ENG_IDLE;
                  cs_n_q <= 1'b1;
               end
            end
            default: begin
               st_q   <= ENG_IDLE;
               cs_n_q <= 1'b1;
            end
         endcase
      end
   end

   assign run      = (st_q == ENG_SHIFT);
   assign cs_n     = cs_n_q;
   assign rx_word  = rx_word_q;
   assign rx_valid = rx_valid_q;

endmodule

// File: rtl/spi_word_engine.sv
module spi_word_engine #(
   parameter int WORD_W         = 32,
   parameter int LEN_W          = 2,
   parameter int UNIT_W         = 8,
   parameter bit RX_CLR_ON_LOAD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_wr,
   input  logic              req_hold,
   input  logic [WORD_W-1:0] req_word,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              ext_cs_n,
   input  logic              miso,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_valid,
   output logic              busy,
   output logic              sck,
   output logic              cs_n,
   output logic              mosi
);

   localparam int MAX_BITS = UNIT_W * (1 << LEN_W);

   generate
      if (MAX_BITS != WORD_W) begin : g_bad_geometry
         $error("WORD_W must equal UNIT_W * 2**LEN_W");
      end
      if (UNIT_W < 1) begin : g_bad_unit
         $error("UNIT_W must be at least 1");
      end
      if (WORD_W < 2) begin : g_bad_word
         $error("WORD_W must be at least 2");
      end
   endgenerate

   logic              load;
   logic [WORD_W-1:0] load_word;
   logic              run;
   logic              rise_now;
   logic              fall_now;
   logic [WORD_W-1:0] rx_sr;

   spi_eng_seq #(
      .WORD_W (WORD_W),
      .LEN_W  (LEN_W),
      .UNIT_W (UNIT_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_wr    (req_wr),
      .req_hold  (req_hold),
      .req_word  (req_word),
      .req_len   (req_len),
      .ext_cs_n  (ext_cs_n),
      .fall_now  (fall_now),
      .rx_sr     (rx_sr),
      .load      (load),
      .load_word (load_word),
      .run       (run),
      .cs_n      (cs_n),
      .rx_word   (rx_word),
      .rx_valid  (rx_valid)
   );

   spi_eng_clkgen u_clkgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .load     (load),
      .sck      (sck),
      .rise_now (rise_now),
      .fall_now (fall_now)
   );

   spi_eng_shifter #(
      .WORD_W         (WORD_W),
      .RX_CLR_ON_LOAD (RX_CLR_ON_LOAD)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_word (load_word),
      .rise_now  (rise_now),
      .fall_now  (fall_now),
      .miso      (miso),
      .mosi      (mosi),
      .rx_sr     (rx_sr)
   );

   assign busy = run;

endmodule

// File: rtl/spi_word_engine_chk.sv
module spi_word_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic req_hold,
   input logic ext_cs_n,
   input logic busy,
   input logic cs_n,
   input logic sck,
   input logic rx_valid
);

   // R4: strobe lasts one cycle
   p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R4: busy only ends with a completed word
   p_busy_end_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> rx_valid);

   // R5: shifting only happens inside a selected transaction
   p_busy_selected_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !cs_n);

   // R5: hold at completion keeps the slave selected
   p_hold_keeps_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !busy && $past(req_hold)) |-> !cs_n);

   // R6: clock idles low
   p_sck_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck);

   // R6: half-rate clock toggles every cycle while shifting
   p_sck_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (sck != $past(sck)));

   // R10: no new transaction while another master is active
   p_no_start_ext_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cs_n && !ext_cs_n) |=> cs_n);

endmodule

bind spi_word_engine spi_word_engine_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_hold (req_hold),
   .ext_cs_n (ext_cs_n),
   .busy     (busy),
   .cs_n     (cs_n),
   .sck      (sck),
   .rx_valid (rx_valid)
);

// File: tb/spi_word_engine_bench.sv
`timescale 1ns/1ps
module spi_word_engine_bench;

   logic        clk;
   logic        rst_n;
   logic        req_wr;
   logic        req_hold;
   logic [31:0] req_word;
   logic [1:0]  req_len;
   logic        ext_cs_n;
   logic        miso;
   logic [31:0] rx_word;
   logic        rx_valid;
   logic        busy;
   logic        sck;
   logic        cs_n;
   logic        mosi;

   int vectors;
   int fails;
   bit finished;

   spi_word_engine u_spi_word_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_wr   (req_wr),
      .req_hold (req_hold),
      .req_word (req_word),
      .req_len  (req_len),
      .ext_cs_n (ext_cs_n),
      .miso     (miso),
      .rx_word  (rx_word),
      .rx_valid (rx_valid),
      .busy     (busy),
      .sck      (sck),
      .cs_n     (cs_n),
      .mosi     (mosi)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   // ---------------- byte-oriented slave model ----------------
   int   slv_n;
   int   cs_falls;
   logic mosi_log [0:255];

   function automatic logic rep_bit(input int n);
      logic [7:0] b;
      b = 8'h5C + 8'((n / 8) * 8'h3B);
      return b[7 - (n % 8)];
   endfunction

   assign miso = rep_bit(slv_n);

   always @(negedge cs_n) begin
      slv_n    = 0;
      cs_falls = cs_falls + 1;
   end

   always @(posedge sck) begin
      if (!cs_n) begin
         mosi_log[slv_n % 256] = mosi;
         slv_n = slv_n + 1;
      end
   end

   // ---------------- expected-value helpers ----------------
   function automatic logic [31:0] exp_rx(input int off, input int n);
      logic [31:0] r;
      r = '0;
      for (int i = 0; i < n; i++) r[n-1-i] = rep_bit(off + i);
      return r;
   endfunction

   function automatic logic [31:0] got_mosi(input int off, input int n);
      logic [31:0] r;
      r = '0;
      for (int i = 0; i < n; i++) r[n-1-i] = mosi_log[(off + i) % 256];
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---------------- transaction tracking ----------------
   bit held_prev;
   int off_next;

   task automatic run_word(input logic [31:0] w, input logic [1:0] len, input logic hold);
      int n;
      int off;
      int falls0;
      n   = 8 * (int'(len) + 1);
      off = held_prev ? off_next : 0;
      falls0 = cs_falls;
      @(negedge clk);
      req_wr = 1'b1; req_word = w; req_len = len; req_hold = hold;
      @(posedge clk);
      @(negedge clk);
      req_wr = 1'b0;
      chk("R4 busy after accept", 32'(busy), 32'd1);
      chk("R6 sck low first half", 32'(sck), 32'd0);
      if (held_prev) chk("R5 no new select", 32'(cs_falls), 32'(falls0));
      else           chk("R5 one select fall", 32'(cs_falls), 32'(falls0 + 1));
      @(posedge clk);
      @(negedge clk);
      chk("R6 sck high second half", 32'(sck), 32'd1);
      repeat (2 * n - 2) @(posedge clk);
      @(negedge clk);
      chk("R1 no early valid", 32'(rx_valid), 32'd0);
      chk("R4 busy before end", 32'(busy), 32'd1);
      @(posedge clk);
      @(negedge clk);
      chk("R1 valid at 2N", 32'(rx_valid), 32'd1);
      chk("R3 rx word", rx_word, exp_rx(off, n));
      chk("R2 mosi order", got_mosi(off, n), w >> (32 - n));
      chk("R4 busy low at end", 32'(busy), 32'd0);
      chk(hold ? "R5 cs held" : "R8 cs released", 32'(cs_n), hold ? 32'd0 : 32'd1);
      @(negedge clk);
      chk("R4 valid one cycle", 32'(rx_valid), 32'd0);
      held_prev = hold;
      off_next  = off + n;
   endtask

   task automatic release_hold();
      @(negedge clk);
      req_hold = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R8 cs release on hold drop", 32'(cs_n), 32'd1);
      held_prev = 1'b0;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [31:0] sw [0:2];
      logic [31:0] w;
      logic [1:0]  l;
      logic        h;
      vectors = 0; fails = 0; finished = 1'b0;
      slv_n = 0; cs_falls = 0; held_prev = 1'b0; off_next = 0;
      rst_n = 1'b0; req_wr = 1'b0; req_hold = 1'b0; req_word = '0;
      req_len = '0; ext_cs_n = 1'b1;
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 cs_n reset", 32'(cs_n), 32'd1);
      chk("R11 sck reset", 32'(sck), 32'd0);
      chk("R11 busy reset", 32'(busy), 32'd0);
      chk("R11 valid reset", 32'(rx_valid), 32'd0);
      chk("R11 rx_word reset", rx_word, 32'd0);
      cs_falls = 0;

      // R1: every length code, fresh transactions
      run_word(32'h9F00_0000, 2'b00, 1'b0);
      run_word(32'h05A5_0000, 2'b01, 1'b0);
      run_word(32'h0B12_3456, 2'b10, 1'b0);
      run_word(32'hC3E1_7F08, 2'b11, 1'b0);

      // R5: held transaction of three words, then release
      run_word(32'h0B00_1000, 2'b11, 1'b1);
      run_word(32'h0000_0000, 2'b00, 1'b1);
      run_word(32'hFFFF_FFFF, 2'b11, 1'b1);
      release_hold();

      // R7: three streamed 32-bit words, hold low throughout
      sw[0] = 32'hDEAD_BEEF; sw[1] = 32'h1357_9BDF; sw[2] = 32'h8000_0001;
      @(negedge clk);
      req_wr = 1'b1; req_word = sw[0]; req_len = 2'b11; req_hold = 1'b0;
      @(posedge clk);
      @(negedge clk);
      req_wr = 1'b0;
      for (int k = 0; k < 3; k++) begin
         repeat (62) @(posedge clk);
         @(negedge clk);
         if (k < 2) begin
            req_wr = 1'b1; req_word = sw[k+1];
         end
         @(posedge clk);
         @(negedge clk);
         req_wr = 1'b0;
         @(posedge clk);
         @(negedge clk);
         chk("R7 valid per word", 32'(rx_valid), 32'd1);
         chk("R7 rx word", rx_word, exp_rx(32 * k, 32));
         chk("R7 mosi word", got_mosi(32 * k, 32), sw[k]);
         chk("R7 busy without gap", 32'(busy), (k < 2) ? 32'd1 : 32'd0);
         chk("R7 cs across stream", 32'(cs_n), (k < 2) ? 32'd0 : 32'd1);
      end
      held_prev = 1'b0;

      // R9: request in the middle of a word is ignored
      @(negedge clk);
      req_wr = 1'b1; req_word = 32'hA55A_0000; req_len = 2'b01;
      @(posedge clk);
      @(negedge clk);
      req_wr = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      req_wr = 1'b1; req_word = 32'h7777_7777; req_len = 2'b11;
      @(posedge clk);
      @(negedge clk);
      req_wr = 1'b0;
      repeat (27) @(posedge clk);
      @(negedge clk);
      chk("R9 original word completes", 32'(rx_valid), 32'd1);
      chk("R9 original mosi", got_mosi(0, 16), 32'h0000_A55A);
      chk("R9 no chained word", 32'(busy), 32'd0);
      repeat (3) @(negedge clk);
      chk("R9 stays idle", 32'(busy), 32'd0);
      chk("R9 cs stays high", 32'(cs_n), 32'd1);

      // R10: foreign master blocks a new transaction
      ext_cs_n = 1'b0;
      @(negedge clk);
      req_wr = 1'b1; req_word = 32'h0600_0000; req_len = 2'b00;
      repeat (2) @(posedge clk);
      @(negedge clk);
      req_wr = 1'b0;
      chk("R10 no select", 32'(cs_n), 32'd1);
      chk("R10 not busy", 32'(busy), 32'd0);
      ext_cs_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R10 request dropped", 32'(busy), 32'd0);

      // random mix of lengths, data and hold
      for (int i = 0; i < 40; i++) begin
         w = $urandom;
         l = 2'($urandom % 4);
         h = 1'($urandom % 2);
         if (held_prev && off_next >= 128) h = 1'b0;
         run_word(w, l, h);
      end
      if (held_prev) release_hold();

      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule